// File: doc/BRIEF.md
# GPIO Port with Address-Masked Data Access

This block is an eight-pin general-purpose I/O port on a simple 32-bit register bus. Software sets each pin's direction, its digital enable and an alternate-function select bit. It then moves pin values through a data window. The window is 256 words long. Word-address bits [9:2] of a data access act as a per-pin mask. A store changes only the output-latch bits named by that mask, and a load returns only those pin bits. This gives each software module atomic control of its own pins, with no read-modify-write sequence and no effect on pins that other code owns.

Pin inputs pass through a synchronizer of parameterised depth before they are read. A pin drives its pad only when it is set as an output, it is digitally enabled, and its alternate select is clear. All widths, register offsets and the synchronizer depth are parameters, and they are checked at elaboration.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output latch, direction, alternate-select and digital-enable registers are all zero, and `pin_oe` and `pin_out` are zero.
- R2: A write whose address has bits [11:10] equal to 0 is a data write. Bits [9:2] of the address form a mask, where mask bit b corresponds to offset 4·2^b. The write loads `bus_wdata[b]` into output-latch bit b only where the mask bit is 1. All other latch bits keep their values.
- R3: A read in the data window returns, on `bus_rdata[7:0]`, the synchronized pin value AND the digital enable AND the address mask. Bits 31:8 read as zero. For example, offset 0x3FC covers all pins and offset 0x038 covers pins 1 to 3.
- R4: The direction register is at offset 0x400, where 1 means output. It reads back its 8 bits with bits 31:8 zero.
- R5: The alternate-select register is at offset 0x420, where 0 means regular I/O. It reads back the same way.
- R6: The digital-enable register is at offset 0x51C, where 1 means the pin is enabled. It reads back the same way.
- R7: `pin_oe[b]` is 1 exactly when direction[b]=1, enable[b]=1 and alternate[b]=0. `pin_out[b]` equals latch bit b when `pin_oe[b]` is 1, and is 0 otherwise.
- R8: A pin whose digital enable is 0 reads as 0 in the data window, whatever its input level.
- R9: A read of an address outside the data window and the three configuration offsets returns 0. A write there changes no register.
- R10: A change on `pin_in` first appears in data reads after exactly SYNC_STAGES rising clock edges (default 2). Reads are combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Per-pin output enables |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- Output enables never lead the digital enable.
- Pads never drive while disabled.
- A masked data write lands only in its selected latch bits.
- Configuration writes take effect on the next edge.
- Unmapped reads return zero.

Only the bench scenarios can show the rest:
- The mask encoding at particular offsets such as 0x038 and 0x3FC.
- The gating of reads by the enable register.
- The exact synchronizer latency.
- The absence of any effect from writes to unmapped addresses, which is observed by reading every register back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   // One-hot decode result for a bus address
   typedef struct packed {
      logic data;
      logic dir;
      logic alt;
      logic den;
   } gpio_hit_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DIR_OFS  = 'h400,
   parameter int unsigned ALT_OFS  = 'h420,
   parameter int unsigned DEN_OFS  = 'h51C
) (
   input  logic [ADDR_W-1:0]   addr,
   output gpio_hit_t           hit,
   output logic [NUM_PINS-1:0] mask
);
   localparam int unsigned WIN_TOP = NUM_PINS + 2;
   localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFS);
   localparam logic [ADDR_W-1:0] ALT_A = ADDR_W'(ALT_OFS);
   localparam logic [ADDR_W-1:0] DEN_A = ADDR_W'(DEN_OFS);

   // The byte lane bits do not take part in the decode
   logic unused_lane;
   assign unused_lane = ^addr[1:0];

   assign mask     = addr[WIN_TOP-1:2];
   assign hit.data = (addr[ADDR_W-1:WIN_TOP] == '0);
   assign hit.dir  = (addr[ADDR_W-1:2] == DIR_A[ADDR_W-1:2]);
   assign hit.alt  = (addr[ADDR_W-1:2] == ALT_A[ADDR_W-1:2]);
   assign hit.den  = (addr[ADDR_W-1:2] == DEN_A[ADDR_W-1:2]);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] d,
   output logic [NUM_PINS-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
   end else begin : g_chain
      logic [NUM_PINS-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign q = stage_q[STAGES-1];
   end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  gpio_hit_t           hit,
   input  logic [NUM_PINS-1:0] mask,
   input  logic [NUM_PINS-1:0] wdata,
   output logic [NUM_PINS-1:0] latch_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] alt_q,
   output logic [NUM_PINS-1:0] den_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         alt_q   <= '0;
         den_q   <= '0;
      end else if (wr) begin
         if (hit.data) latch_q <= (latch_q & ~mask) | (wdata & mask);
         if (hit.dir)  dir_q   <= wdata;
         if (hit.alt)  alt_q   <= wdata;
         if (hit.den)  den_q   <= wdata;
      end
   end

   // Masked data store: selected bits take the new value, the others hold
   p_masked_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit.data) |=>
         ((((latch_q ^ $past(wdata)) & $past(mask)) == '0) &&
          (((latch_q ^ $past(latch_q)) & ~$past(mask)) == '0)));

   p_dir_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit.dir) |=> (dir_q == $past(wdata)));

   p_alt_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit.alt) |=> (alt_q == $past(wdata)));

   p_den_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit.den) |=> (den_q == $past(wdata)));

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr || hit == '0) |=>
         ($stable(latch_q) && $stable(dir_q) && $stable(alt_q) && $stable(den_q)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
   parameter int unsigned NUM_PINS = 8
) (
   input  logic [NUM_PINS-1:0] latch_q,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] alt_q,
   input  logic [NUM_PINS-1:0] den_q,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   for (genvar b = 0; b < NUM_PINS; b++) begin : g_pin
      assign pin_oe[b]  = dir_q[b] & den_q[b] & ~alt_q[b];
      assign pin_out[b] = pin_oe[b] & latch_q[b];
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIR_OFS     = 'h400,
   parameter int unsigned ALT_OFS     = 'h420,
   parameter int unsigned DEN_OFS     = 'h51C
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   localparam int unsigned WIN_TOP = NUM_PINS + 2;

   // Elaboration-time parameter checks
   if (WIN_TOP >= ADDR_W) begin : g_err_addr
      $error("address too narrow for the data window");
   end
   if (NUM_PINS > DATA_W) begin : g_err_data
      $error("more pins than data bits");
   end
   if ((DIR_OFS >> WIN_TOP) == 0 || (ALT_OFS >> WIN_TOP) == 0 ||
       (DEN_OFS >> WIN_TOP) == 0) begin : g_err_ofs
      $error("configuration offset overlaps the data window");
   end
   if (((DIR_OFS | ALT_OFS | DEN_OFS) & 3) != 0) begin : g_err_align
      $error("configuration offsets must be word aligned");
   end
   if (DIR_OFS == ALT_OFS || DIR_OFS == DEN_OFS || ALT_OFS == DEN_OFS) begin : g_err_dup
      $error("configuration offsets must differ");
   end

   gpio_hit_t           hit;
   logic [NUM_PINS-1:0] mask;
   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] latch_q, dir_q, alt_q, den_q;

   logic unused_wdata;
   if (DATA_W > NUM_PINS) begin : g_wide
      assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_PINS];
   end else begin : g_narrow
      assign unused_wdata = 1'b0;
   end

   gpio_addr_decode #(
      .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
      .DIR_OFS(DIR_OFS), .ALT_OFS(ALT_OFS), .DEN_OFS(DEN_OFS)
   ) u_dec (
      .addr(bus_addr),
      .hit (hit),
      .mask(mask)
   );

   gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (pin_sync)
   );

   gpio_regbank #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .hit    (hit),
      .mask   (mask),
      .wdata  (bus_wdata[NUM_PINS-1:0]),
      .latch_q(latch_q),
      .dir_q  (dir_q),
      .alt_q  (alt_q),
      .den_q  (den_q)
   );

   gpio_pad_ctrl #(.NUM_PINS(NUM_PINS)) u_pads (
      .latch_q(latch_q),
      .dir_q  (dir_q),
      .alt_q  (alt_q),
      .den_q  (den_q),
      .pin_out(pin_out),
      .pin_oe (pin_oe)
   );

   // Read mux: the data window returns gated, masked pin levels
   always_comb begin
      bus_rdata = '0;
      if (hit.data)     bus_rdata[NUM_PINS-1:0] = pin_sync & den_q & mask;
      else if (hit.dir) bus_rdata[NUM_PINS-1:0] = dir_q;
      else if (hit.alt) bus_rdata[NUM_PINS-1:0] = alt_q;
      else if (hit.den) bus_rdata[NUM_PINS-1:0] = den_q;
   end

   p_oe_needs_den_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & ~den_q) == '0) && ((pin_oe & alt_q) == '0));

   p_quiet_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   p_disabled_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit.data |-> ((bus_rdata[NUM_PINS-1:0] & ~den_q) == '0));

   p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (bus_rdata == '0));

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out, pin_oe;

   int n_checks = 0;
   int n_fail   = 0;

   // Expected state, kept from the requirements
   logic [7:0] e_latch = '0, e_dir = '0, e_alt = '0, e_den = '0;

   always #2.5 clk = ~clk;

   gpio_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [7:0] exp_oe();
      return e_dir & e_den & ~e_alt;
   endfunction

   task automatic set_pins(input logic [7:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(12'h400, v); chk("R1 dir", v, 0);
      rd(12'h420, v); chk("R1 alt", v, 0);
      rd(12'h51C, v); chk("R1 den", v, 0);
      chk("R1 oe", {24'h0, pin_oe}, 0);
      chk("R1 out", {24'h0, pin_out}, 0);
   endtask

   task automatic t_config();
      logic [31:0] v;
      wr(12'h400, 32'hDEAD_BEA5); e_dir = 8'hA5;
      wr(12'h420, 32'h1234_5618); e_alt = 8'h18;
      wr(12'h51C, 32'hFFFF_FF3C); e_den = 8'h3C;
      @(negedge clk);
      rd(12'h400, v); chk("R4 dir readback", v, {24'h0, e_dir});
      rd(12'h420, v); chk("R5 alt readback", v, {24'h0, e_alt});
      rd(12'h51C, v); chk("R6 den readback", v, {24'h0, e_den});
   endtask

   task automatic t_masked_write();
      wr(12'h400, 32'hFF); e_dir = 8'hFF;
      wr(12'h420, 32'h00); e_alt = 8'h00;
      wr(12'h51C, 32'hFF); e_den = 8'hFF;
      wr(12'h3FC, 32'h0000_005A); e_latch = 8'h5A;
      #1 chk("R2 full mask write", {24'h0, pin_out}, {24'h0, e_latch});
      // offset 0x038 selects pins 1..3
      wr(12'h038, 32'hFFFF_FFF0); e_latch = (e_latch & ~8'h0E) | (8'hF0 & 8'h0E);
      #1 chk("R2 mask 0x038 write", {24'h0, pin_out}, {24'h0, e_latch});
      // single-bit set of pin 7 at 4*2^7 = 0x200
      wr(12'h200, 32'h80); e_latch = e_latch | 8'h80;
      #1 chk("R2 single bit set", {24'h0, pin_out}, {24'h0, e_latch});
      // empty mask at 0x000 writes nothing
      wr(12'h000, 32'hFF);
      #1 chk("R2 empty mask", {24'h0, pin_out}, {24'h0, e_latch});
   endtask

   task automatic t_masked_read();
      logic [31:0] v;
      set_pins(8'hC3);
      rd(12'h3FC, v); chk("R3 read all", v, {24'h0, 8'hC3 & e_den});
      rd(12'h038, v); chk("R3 read mask 0x038", v, {24'h0, 8'hC3 & e_den & 8'h0E});
      rd(12'h104, v); chk("R3 read pins 6,0", v, {24'h0, 8'hC3 & e_den & 8'h41});
   endtask

   task automatic t_den_gating();
      logic [31:0] v;
      wr(12'h51C, 32'h0F); e_den = 8'h0F;
      set_pins(8'hFF);
      rd(12'h3FC, v); chk("R8 disabled pins read 0", v, 32'h0F);
   endtask

   task automatic t_oe_rules();
      wr(12'h400, 32'hF0); e_dir = 8'hF0;
      wr(12'h51C, 32'hCC); e_den = 8'hCC;
      wr(12'h420, 32'h40); e_alt = 8'h40;
      wr(12'h3FC, 32'hFF); e_latch = 8'hFF;
      #1;
      chk("R7 oe", {24'h0, pin_oe}, {24'h0, exp_oe()});
      chk("R7 out", {24'h0, pin_out}, {24'h0, exp_oe() & e_latch});
      wr(12'h3FC, 32'h00); e_latch = 8'h00;
      #1 chk("R7 out low", {24'h0, pin_out}, 0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(12'h404, 32'hFF);
      wr(12'h600, 32'hFF);
      wr(12'hFFC, 32'hFF);
      rd(12'h404, v); chk("R9 unmapped read 0x404", v, 0);
      rd(12'hFFC, v); chk("R9 unmapped read 0xFFC", v, 0);
      rd(12'h400, v); chk("R9 dir kept", v, {24'h0, e_dir});
      rd(12'h420, v); chk("R9 alt kept", v, {24'h0, e_alt});
      rd(12'h51C, v); chk("R9 den kept", v, {24'h0, e_den});
      #1 chk("R9 latch kept", {24'h0, pin_out}, {24'h0, exp_oe() & e_latch});
   endtask

   task automatic t_sync();
      logic [31:0] v;
      wr(12'h51C, 32'hFF); e_den = 8'hFF;
      set_pins(8'h00);
      @(negedge clk);
      pin_in = 8'h96;
      bus_addr = 12'h3FC;
      @(negedge clk);
      rd(12'h3FC, v); chk("R10 after one edge", v, 0);
      @(negedge clk);
      rd(12'h3FC, v); chk("R10 after two edges", v, 32'h96);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_config();
      t_masked_write();
      t_masked_read();
      t_den_gating();
      t_oe_rules();
      t_unmapped();
      t_sync();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule